// File: doc/BRIEF.md
# Trigger-Accept Readout Buffer

This block parks the pixel data of each beam crossing while the first-level trigger decides whether to keep it. Pixel data arrive as 32-bit slices. Each finder cell supplies three slices, so one crossing from eight cells fills twenty-four slices. Complete events wait in a small ring of storage slots until a decision arrives.

A reject returns the slot to the free pool, and the next event to arrive overwrites it. An accept places the slot in a short queue. A serializer takes slots from the queue one at a time and streams each one onto a 16-bit link, one half-word per clock, with a valid flag and a one-cycle end-of-event marker. One event of 768 bits becomes 48 words.

Decisions apply to held events in the order those events finished arriving. An accept that finds the queue full is lost, and so is an event that starts when its slot is still occupied. Either loss sets a sticky error flag.

Top module: `rb_readout_buffer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `out_last`, `busy` and `err` are low.
- R2: An event is exactly NCELL*NSLICE (24) slice strobes. Slice number s of an event is the s-th strobe, where s = cell*3 + slice. After the last strobe the event waits for a decision.
- R3: Each decision strobe applies to the oldest event still waiting for a decision. A decision strobe when no event is waiting has no effect on the output, `busy` or `err`.
- R4: An accepted event comes out as 48 words. Word k carries bits [15:0] of slice k/2 when k is even and bits [31:16] when k is odd. The order is therefore cell 0..7, slice 0..2 within a cell, low half before high half.
- R5: `out_last` is high only with the 48th word of an event, for exactly one cycle.
- R6: If the serializer is idle and the queue is empty, the first word appears on the second clock edge after the edge that samples the accept. The 48 words of an event occupy consecutive cycles.
- R7: A rejected event produces no output, and its slot is freed for reuse by later events.
- R8: Accepts that arrive during a readout are queued, and events are streamed in accept order. `busy` is high while a readout runs or an accept is queued.
- R9: An accept that arrives while QDEPTH (2) accepts are already queued discards that event and sets `err`. `err` stays set until reset.
- R10: An event whose first slice arrives when the next slot in the ring is still occupied is discarded completely and sets `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slice_we | input | 1 | Slice write strobe |
| slice_data | input | 32 | Pixel slice |
| dec_valid | input | 1 | Trigger decision strobe |
| dec_accept | input | 1 | Decision value: 1 accept, 0 reject |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Output half-word |
| out_last | output | 1 | Final word of an event |
| busy | output | 1 | Readout running or accept queued |
| err | output | 1 | Sticky loss flag |

## Verification
The checks assume that slices always arrive in whole events of 24 strobes, so the write position returns to zero only at an event boundary. They also assume that each decision strobe lasts a single cycle and decides one event. The stimulus writes only complete events, with strobes in consecutive cycles, and sends one-cycle decisions, either isolated or back to back. Back-to-back decisions are used to fill the accept queue exactly, and then to overflow it by one.

// File: rtl/rb_pkg.sv
package rb_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_FILL = 2'd1,
        SLOT_HELD = 2'd2,
        SLOT_ACC  = 2'd3
    } slot_st_e;
endpackage

// File: rtl/rb_slice_store.sv
module rb_slice_store #(
    parameter int NSLOT   = 4,
    parameter int NSEG    = 24,
    parameter int SLICE_W = 32,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int SEG_W  = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic               clk,
    input  logic               we_i,
    input  logic [SLOT_W-1:0]  wslot_i,
    input  logic [SEG_W-1:0]   wseg_i,
    input  logic [SLICE_W-1:0] wdata_i,
    input  logic [SLOT_W-1:0]  rslot_i,
    input  logic [SEG_W-1:0]   rseg_i,
    output logic [SLICE_W-1:0] rdata_o
);
    localparam int DEPTH  = NSLOT * NSEG;
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [SLICE_W-1:0] mem_q [DEPTH];
    logic [ADDR_W-1:0]  waddr;
    logic [ADDR_W-1:0]  raddr;

    always_comb begin
        waddr = ADDR_W'(wslot_i) * ADDR_W'(NSEG) + ADDR_W'(wseg_i);
        raddr = ADDR_W'(rslot_i) * ADDR_W'(NSEG) + ADDR_W'(rseg_i);
    end

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr];
endmodule

// File: rtl/rb_accept_fifo.sv
module rb_accept_fifo #(
    parameter int W     = 2,
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] wdata_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t f_d, f_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d = f_q;
        if (push_i) begin
            f_d.ent[f_q.wr] = wdata_i;
            f_d.wr          = bump(f_q.wr);
        end
        if (pop_i) begin
            f_d.rd = bump(f_q.rd);
        end
        if (push_i && !pop_i) begin
            f_d.cnt = f_q.cnt + 1'b1;
        end else if (pop_i && !push_i) begin
            f_d.cnt = f_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign head_o  = f_q.ent[f_q.rd];
    assign empty_o = (f_q.cnt == '0);
    assign full_o  = (f_q.cnt == CNT_W'(DEPTH));

    // R9: the controller never pushes into a full queue
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (f_q.cnt != CNT_W'(DEPTH)));
    // R8: the serializer only starts when an accept is queued
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (f_q.cnt != '0));
endmodule

// File: rtl/rb_serializer.sv
module rb_serializer #(
    parameter int NSLOT   = 4,
    parameter int NSEG    = 24,
    parameter int SLICE_W = 32,
    parameter int OUT_W   = 16,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int SEG_W  = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int HALVES = SLICE_W / OUT_W,
    localparam int NWORD  = NSEG * HALVES,
    localparam int CNT_W  = (NWORD > 1) ? $clog2(NWORD) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [SLOT_W-1:0]  slot_i,
    output logic [SLOT_W-1:0]  rd_slot_o,
    output logic [SEG_W-1:0]   rd_seg_o,
    input  logic [SLICE_W-1:0] rd_data_i,
    output logic               active_o,
    output logic               done_o,
    output logic               out_valid_o,
    output logic [OUT_W-1:0]   out_data_o,
    output logic               out_last_o
);
    typedef struct packed {
        logic              active;
        logic [SLOT_W-1:0] slot;
        logic [CNT_W-1:0]  cnt;
        logic              valid;
        logic [OUT_W-1:0]  data;
        logic              last;
    } ser_t;

    ser_t s_d, s_q;
    logic final_word;
    int   part;

    always_comb begin
        final_word = s_q.active && (s_q.cnt == CNT_W'(NWORD - 1));
        part       = int'(s_q.cnt) % HALVES;
        rd_seg_o   = SEG_W'(int'(s_q.cnt) / HALVES);
        rd_slot_o  = s_q.slot;

        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.last  = 1'b0;
        s_d.data  = '0;
        if (s_q.active) begin
            s_d.valid = 1'b1;
            s_d.data  = rd_data_i[part*OUT_W +: OUT_W];
            s_d.last  = final_word;
            if (final_word) begin
                s_d.active = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        if (start_i) begin
            s_d.active = 1'b1;
            s_d.slot   = slot_i;
            s_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o    = s_q.active;
    assign done_o      = final_word;
    assign out_valid_o = s_q.valid;
    assign out_data_o  = s_q.data;
    assign out_last_o  = s_q.last;

    // R5: the end marker never appears without a word
    p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.last |-> s_q.valid);
    // R6: a running readout emits a word in every following cycle
    p_run_contig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |=> s_q.valid);
    // R4: the word index stays within one event
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |-> (int'(s_q.cnt) < NWORD));
    // R8: a new readout only starts while idle
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !s_q.active);
endmodule

// File: rtl/rb_readout_buffer.sv
module rb_readout_buffer
    import rb_pkg::*;
#(
    parameter int NSLOT   = 4,
    parameter int NCELL   = 8,
    parameter int NSLICE  = 3,
    parameter int SLICE_W = 32,
    parameter int OUT_W   = 16,
    parameter int QDEPTH  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slice_we,
    input  logic [SLICE_W-1:0] slice_data,
    input  logic               dec_valid,
    input  logic               dec_accept,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_data,
    output logic               out_last,
    output logic               busy,
    output logic               err
);
    localparam int NSEG   = NCELL * NSLICE;
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int SEG_W  = (NSEG > 1) ? $clog2(NSEG) : 1;

    typedef struct packed {
        slot_st_e [NSLOT-1:0] st;
        logic [SLOT_W-1:0]    wr_slot;
        logic [SEG_W-1:0]     wr_seg;
        logic                 wr_drop;
        logic [SLOT_W-1:0]    dec_slot;
        logic                 err;
    } ctl_t;

    ctl_t c_d, c_q;

    logic               store_we;
    logic [SLICE_W-1:0] rd_data;
    logic [SLOT_W-1:0]  rd_slot;
    logic [SEG_W-1:0]   rd_seg;
    logic               ser_start, ser_active, ser_done;
    logic               q_push, q_pop, q_empty, q_full;
    logic [SLOT_W-1:0]  q_head;
    logic               drop_now;

    function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] p);
        return (p == SLOT_W'(NSLOT - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        c_d       = c_q;
        ser_start = 1'b0;
        q_pop     = 1'b0;
        q_push    = 1'b0;
        store_we  = 1'b0;
        drop_now  = (c_q.wr_seg == '0) ? (c_q.st[c_q.wr_slot] != SLOT_FREE) : c_q.wr_drop;

        // readout retires its slot after the final word
        if (ser_done) begin
            c_d.st[rd_slot] = SLOT_FREE;
        end
        // launch the next queued readout
        if (!ser_active && !q_empty) begin
            ser_start = 1'b1;
            q_pop     = 1'b1;
        end
        // trigger decision on the oldest held event
        if (dec_valid && (c_q.st[c_q.dec_slot] == SLOT_HELD)) begin
            if (!dec_accept) begin
                c_d.st[c_q.dec_slot] = SLOT_FREE;
            end else if (q_full) begin
                c_d.st[c_q.dec_slot] = SLOT_FREE;
                c_d.err              = 1'b1;
            end else begin
                q_push               = 1'b1;
                c_d.st[c_q.dec_slot] = SLOT_ACC;
            end
            c_d.dec_slot = next_slot(c_q.dec_slot);
        end
        // slice capture
        if (slice_we) begin
            if (c_q.wr_seg == '0) begin
                c_d.wr_drop = drop_now;
                if (drop_now) begin
                    c_d.err = 1'b1;
                end else begin
                    c_d.st[c_q.wr_slot] = SLOT_FILL;
                end
            end
            store_we = !drop_now;
            if (c_q.wr_seg == SEG_W'(NSEG - 1)) begin
                c_d.wr_seg = '0;
                if (!drop_now) begin
                    c_d.st[c_q.wr_slot] = SLOT_HELD;
                    c_d.wr_slot         = next_slot(c_q.wr_slot);
                end
            end else begin
                c_d.wr_seg = c_q.wr_seg + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    rb_slice_store #(
        .NSLOT(NSLOT), .NSEG(NSEG), .SLICE_W(SLICE_W)
    ) u_store (
        .clk    (clk),
        .we_i   (store_we),
        .wslot_i(c_q.wr_slot),
        .wseg_i (c_q.wr_seg),
        .wdata_i(slice_data),
        .rslot_i(rd_slot),
        .rseg_i (rd_seg),
        .rdata_o(rd_data)
    );

    rb_accept_fifo #(
        .W(SLOT_W), .DEPTH(QDEPTH)
    ) u_queue (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (q_push),
        .wdata_i(c_q.dec_slot),
        .pop_i  (q_pop),
        .head_o (q_head),
        .empty_o(q_empty),
        .full_o (q_full)
    );

    rb_serializer #(
        .NSLOT(NSLOT), .NSEG(NSEG), .SLICE_W(SLICE_W), .OUT_W(OUT_W)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (ser_start),
        .slot_i     (q_head),
        .rd_slot_o  (rd_slot),
        .rd_seg_o   (rd_seg),
        .rd_data_i  (rd_data),
        .active_o   (ser_active),
        .done_o     (ser_done),
        .out_valid_o(out_valid),
        .out_data_o (out_data),
        .out_last_o (out_last)
    );

    assign busy = ser_active || !q_empty;
    assign err  = c_q.err;

    // R9: the loss flag is sticky
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.err |=> c_q.err);
    // R8: the slot being streamed stays reserved for the readout
    p_read_slot_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ser_active |-> (c_q.st[rd_slot] == SLOT_ACC));
    // R7: the capture position never writes into a slot owned by a decision or readout
    p_write_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |-> (c_q.st[c_q.wr_slot] inside {SLOT_FREE, SLOT_FILL}));
    // R3: the decision pointer lags the capture pointer in completion order
    p_dec_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st[c_q.dec_slot] == SLOT_HELD) |=> 
        ((c_q.st[$past(c_q.dec_slot)] != SLOT_FILL)));
endmodule

// File: tb/rb_readout_buffer_tb.sv
`timescale 1ns/1ps
module rb_readout_buffer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slice_we = 1'b0;
    logic [31:0] slice_data = '0;
    logic        dec_valid = 1'b0;
    logic        dec_accept = 1'b0;
    logic        out_valid, out_last, busy, err;
    logic [15:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int got_n   = 0;
    logic [15:0] got_data [512];
    logic        got_last [512];
    int          got_cyc  [512];
    bit          done = 1'b0;

    rb_readout_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .slice_we(slice_we), .slice_data(slice_data),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .busy(busy), .err(err)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid && got_n < 512) begin
            got_data[got_n] = out_data;
            got_last[got_n] = out_last;
            got_cyc[got_n]  = cyc;
            got_n = got_n + 1;
        end
    end

    function automatic logic [31:0] pat(input int ev, input int s);
        return {8'(ev), 8'(s), ~8'(ev), 8'(s) ^ 8'h5A};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; slice_we = 1'b0; dec_valid = 1'b0; dec_accept = 1'b0;
        repeat (3) @(negedge clk);
        got_n = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_event(input int ev);
        for (int s = 0; s < 24; s++) begin
            @(negedge clk);
            slice_we = 1'b1;
            slice_data = pat(ev, s);
        end
        @(negedge clk);
        slice_we = 1'b0;
    endtask

    task automatic decide(input logic [7:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dec_valid = 1'b1;
            dec_accept = bits[i];
        end
        @(negedge clk);
        dec_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int idle = 0;
        while (idle < 4) begin
            @(negedge clk);
            if (!busy && !out_valid) idle++; else idle = 0;
        end
    endtask

    task automatic check_event(input int base, input int ev, input string tag);
        int bad = -1;
        int lastbad = -1;
        for (int k = 0; k < 48; k++) begin
            logic [31:0] sl = pat(ev, k / 2);
            logic [15:0] e  = (k % 2 == 0) ? sl[15:0] : sl[31:16];
            if (bad < 0 && got_data[base + k] !== e) bad = k;
            if (lastbad < 0 && got_last[base + k] !== (k == 47)) lastbad = k;
        end
        chk(bad < 0, {tag, " R4 word order/data"},
            (bad < 0) ? 0 : int'(got_data[base + bad]),
            (bad < 0) ? 0 : int'((bad % 2 == 0) ? pat(ev, bad / 2) & 32'hFFFF : pat(ev, bad / 2) >> 16));
        chk(lastbad < 0, {tag, " R5 last marker position"}, lastbad, 47);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!out_valid && !out_last && !busy && !err, "R1 outputs in reset",
            int'({out_valid, out_last, busy, err}), 0);
        do_reset();
        chk(!out_valid && !out_last && !busy && !err, "R1 outputs after reset",
            int'({out_valid, out_last, busy, err}), 0);
    endtask

    task automatic t_single();
        logic v1, v2;
        do_reset();
        write_event(1);
        @(negedge clk);
        dec_valid = 1'b1; dec_accept = 1'b1;
        @(posedge clk);
        @(negedge clk);
        dec_valid = 1'b0;
        @(negedge clk);
        v1 = out_valid;
        @(negedge clk);
        v2 = out_valid;
        chk(!v1 && v2, "R6 first word on second edge after accept", int'({v1, v2}), 1);
        wait_idle();
        chk(got_n == 48, "R2 one event yields 48 words", got_n, 48);
        check_event(0, 1, "single");
        chk(got_cyc[47] - got_cyc[0] == 47, "R6 words contiguous", got_cyc[47] - got_cyc[0], 47);
    endtask

    task automatic t_reject();
        do_reset();
        write_event(2);
        decide(8'h00, 1);
        repeat (60) @(negedge clk);
        chk(got_n == 0, "R7 rejected event not sent", got_n, 0);
        for (int e = 10; e < 14; e++) begin
            write_event(e);
            decide(8'h00, 1);
        end
        write_event(14);
        decide(8'h01, 1);
        wait_idle();
        chk(got_n == 48 && !err, "R7 freed slots reused", got_n, 48);
        check_event(0, 14, "reuse R7");
    endtask

    task automatic t_order();
        do_reset();
        decide(8'h01, 1);
        repeat (20) @(negedge clk);
        chk(got_n == 0 && !busy && !err, "R3 decision with nothing held ignored",
            got_n + int'(busy) + int'(err), 0);
        write_event(20);
        write_event(21);
        decide(8'h02, 2);
        wait_idle();
        chk(got_n == 48, "R3 only second event accepted", got_n, 48);
        check_event(0, 21, "oldest-first R3");
    endtask

    task automatic t_queue();
        logic b;
        do_reset();
        write_event(22);
        write_event(23);
        write_event(24);
        decide(8'h07, 3);
        b = busy;
        chk(b, "R8 busy while queued/reading", int'(b), 1);
        wait_idle();
        chk(got_n == 144 && !err, "R8 three queued events all sent", got_n, 144);
        check_event(0, 22, "queue R8 #0");
        check_event(48, 23, "queue R8 #1");
        check_event(96, 24, "queue R8 #2");
    endtask

    task automatic t_overflow();
        do_reset();
        for (int e = 30; e < 34; e++) write_event(e);
        chk(!err, "R9 no error before overflow", int'(err), 0);
        decide(8'h0F, 4);
        wait_idle();
        chk(err, "R9 overflow sets err", int'(err), 1);
        chk(got_n == 144, "R9 overflowed event dropped", got_n, 144);
        check_event(96, 32, "overflow R9");
        write_event(35);
        decide(8'h01, 1);
        wait_idle();
        chk(err, "R9 err stays set", int'(err), 1);
    endtask

    task automatic t_nofree();
        do_reset();
        for (int e = 40; e < 44; e++) write_event(e);
        write_event(44);
        chk(err, "R10 event without free slot sets err", int'(err), 1);
        decide(8'h08, 4);
        wait_idle();
        decide(8'h01, 1);
        repeat (60) @(negedge clk);
        chk(got_n == 48, "R10 discarded event never sent", got_n, 48);
        check_event(0, 43, "nofree R10");
    endtask

    initial begin
        t_reset();
        t_single();
        t_reject();
        t_order();
        t_queue();
        t_overflow();
        t_nofree();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule